// File: doc/BRIEF.md
# Shadow Cache Line Utilization Monitor

This block is a tag-only shadow of a set-associative data cache. It holds no data. It watches a stream of load and store samples, keeps for every resident line a bitmask of the bytes that have been touched, and measures how much of each line was actually used before it left the cache. Each sample carries a physical address, a byte count and a load/store flag, and is offered on a valid/ready handshake.

When a sample misses a full set, the least recently used line is pushed out. Its touched-byte mask, the number of touched bytes and a fixed-point utilization fraction appear on a one-cycle report. A sample whose bytes run past the end of a line is split into two lookups on consecutive cycles, and the input is held off for the second one. Running totals cover accesses, loads, stores, bytes, line-crossing accesses, evictions and used bytes, together with the smallest and largest used-byte count seen on any evicted line.

Top module: `clu_monitor`

## Requirements
- R1: With default parameters (32-bit address, 16 KiB, 4 ways, 64-byte lines, 64 sets), address bits [5:0] are the byte offset, bits [11:6] select the set and bits [31:12] are the tag. A lookup in one set never changes another set.
- R2: A sample whose tag matches a valid way of its set ORs the bytes it covers into that line's mask and produces no report.
- R3: A miss in a set that still has an invalid way fills the lowest-numbered invalid way with the new tag and a mask holding only the sample's bytes. No report is produced.
- R4: A miss in a full set evicts a line and retags it. In the cycle after the lookup, ev_valid_o is high for one cycle with the victim's 64-bit mask (bit i = byte i) in ev_mask_o, its popcount in ev_bytes_o and its utilization in ev_util_o, which equals ev_bytes_o*256/64 (9 bits, 8 fraction bits).
- R5: The victim is the least recently used way of the set. Every hit or fill makes its way the most recent.
- R6: A sample with offset+size > 64 counts once in span_total_o. Its first lookup covers the bytes up to the line end. A second lookup in the next cycle covers the remaining bytes at offset 0 of the following line. smp_ready_o is low for exactly that one cycle. A sample with offset+size = 64 is not a span.
- R7: Each accepted sample (smp_valid_i and smp_ready_o) adds 1 to acc_total_o. It also adds 1 to store_total_o (smp_store_i=1) or to load_total_o (smp_store_i=0), and adds smp_size_i to byte_total_o, once even when split. Legal sizes are 1 to 16.
- R8: Each eviction report adds 1 to evict_total_o and adds ev_bytes_o to used_total_o. All totals update at the same clock edge that loads the report.
- R9: min_used_o and max_used_o hold the smallest and largest ev_bytes_o of all evictions so far. After reset they are 64 and 0.
- R10: After reset all lines are invalid, all totals are zero, smp_ready_o is high and ev_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample offered |
| smp_ready_o | output | 1 | Sample accepted when high together with valid |
| smp_addr_i | input | 32 | Physical byte address |
| smp_size_i | input | 5 | Bytes accessed, 1 to 16 |
| smp_store_i | input | 1 | 1 = store, 0 = load |
| ev_valid_o | output | 1 | Eviction report strobe |
| ev_mask_o | output | 64 | Touched-byte mask of the evicted line |
| ev_bytes_o | output | 7 | Touched-byte count of the evicted line |
| ev_util_o | output | 9 | Utilization, 8 fraction bits |
| acc_total_o | output | 32 | Accepted samples |
| load_total_o | output | 32 | Accepted loads |
| store_total_o | output | 32 | Accepted stores |
| byte_total_o | output | 32 | Sum of sample sizes |
| span_total_o | output | 32 | Line-crossing samples |
| evict_total_o | output | 32 | Evictions |
| used_total_o | output | 32 | Sum of touched bytes over evicted lines |
| min_used_o | output | 7 | Fewest touched bytes on an evicted line |
| max_used_o | output | 7 | Most touched bytes on an evicted line |

## Verification
The second lookup of a line-crossing sample can miss a full set, so an eviction report and a split lookup can occupy the same cycle. The split lookup itself can also evict, which gives two reports back to back while the input is held off. The bench fills two neighbouring sets and then issues a sample that crosses from the first into the second. It expects ready low and a one-byte victim report in the cycle after acceptance, then a second one-byte report with ready high again, and the span and eviction totals stepping by one and two. It then forces out both newly filled lines and checks that their masks hold exactly the two bytes written on each side of the boundary.

// File: rtl/clu_pkg.sv
package clu_pkg;
  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;
endpackage

// File: rtl/clu_addr_split.sv
module clu_addr_split #(
  parameter int AW         = 32,
  parameter int OFF_W      = 6,
  parameter int SZ_W       = 5,
  parameter int LINE_BYTES = 64
) (
  input  logic [AW-1:0]       addr_i,
  input  logic [SZ_W-1:0]     size_i,
  output logic [AW-OFF_W-1:0] line_o,
  output logic [OFF_W-1:0]    off_o,
  output logic [SZ_W-1:0]     first_n_o,
  output logic [SZ_W-1:0]     rest_n_o,
  output logic                span_o
);
  localparam int SW = ((SZ_W > OFF_W + 1) ? SZ_W : OFF_W + 1) + 1;

  logic [SW-1:0] room_w, size_w;

  assign line_o = addr_i[AW-1:OFF_W];
  assign off_o  = addr_i[OFF_W-1:0];
  assign room_w = SW'(LINE_BYTES) - SW'(off_o);
  assign size_w = SW'(size_i);
  assign span_o = size_w > room_w;
  assign first_n_o = span_o ? SZ_W'(room_w) : size_i;
  assign rest_n_o  = span_o ? SZ_W'(size_w - room_w) : '0;
endmodule

// File: rtl/clu_way_select.sv
module clu_way_select #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int AGE_W = 2,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [WAYS-1:0][AGE_W-1:0]  ages_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic                        hit_o,
  output logic                        victim_valid_o,
  output logic [WAY_W-1:0]            way_o,
  output logic [WAYS-1:0][AGE_W-1:0]  ages_o
);
  logic have_inv;

  always_comb begin
    hit_o    = 1'b0;
    have_inv = 1'b0;
    way_o    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_i[w] && tags_i[w] == tag_i) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
      end
    end
    if (!hit_o) begin
      // lowest invalid way wins
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!valid_i[w]) begin
          have_inv = 1'b1;
          way_o    = WAY_W'(w);
        end
      end
      if (!have_inv) begin
        for (int w = 0; w < WAYS; w++) begin
          if (ages_i[w] == AGE_W'(WAYS - 1)) way_o = WAY_W'(w);
        end
      end
    end
    victim_valid_o = !hit_o && !have_inv;
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == way_o)            ages_o[w] = '0;
      else if (ages_i[w] < ages_i[way_o]) ages_o[w] = ages_i[w] + 1'b1;
      else                                ages_o[w] = ages_i[w];
    end
  end
endmodule

// File: rtl/clu_stats.sv
module clu_stats #(
  parameter int CW         = 32,
  parameter int SZ_W       = 5,
  parameter int CNT_W      = 7,
  parameter int LINE_BYTES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             store_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic             span_i,
  input  logic             evict_i,
  input  logic [CNT_W-1:0] evict_bytes_i,
  output logic [CW-1:0]    acc_o,
  output logic [CW-1:0]    load_o,
  output logic [CW-1:0]    store_o,
  output logic [CW-1:0]    bytes_o,
  output logic [CW-1:0]    span_o,
  output logic [CW-1:0]    evict_o,
  output logic [CW-1:0]    used_o,
  output logic [CNT_W-1:0] min_o,
  output logic [CNT_W-1:0] max_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= '0;
      load_o  <= '0;
      store_o <= '0;
      bytes_o <= '0;
      span_o  <= '0;
      evict_o <= '0;
      used_o  <= '0;
      min_o   <= CNT_W'(LINE_BYTES);
      max_o   <= '0;
    end else begin
      if (take_i) begin
        acc_o   <= acc_o + 1'b1;
        bytes_o <= bytes_o + CW'(size_i);
        if (store_i) store_o <= store_o + 1'b1;
        else         load_o  <= load_o + 1'b1;
        if (span_i)  span_o  <= span_o + 1'b1;
      end
      if (evict_i) begin
        evict_o <= evict_o + 1'b1;
        used_o  <= used_o + CW'(evict_bytes_i);
        if (evict_bytes_i < min_o) min_o <= evict_bytes_i;
        if (evict_bytes_i > max_o) max_o <= evict_bytes_i;
      end
    end
  end
endmodule

// File: rtl/clu_monitor.sv
module clu_monitor
  import clu_pkg::*;
#(
  parameter int AW          = 32,
  parameter int CACHE_BYTES = 16384,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 64,
  parameter int MAX_SIZE    = 16,
  parameter int CW          = 32,
  parameter int UTIL_FRAC   = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          smp_valid_i,
  output logic                          smp_ready_o,
  input  logic [AW-1:0]                 smp_addr_i,
  input  logic [$clog2(MAX_SIZE+1)-1:0] smp_size_i,
  input  logic                          smp_store_i,
  output logic                          ev_valid_o,
  output logic [LINE_BYTES-1:0]         ev_mask_o,
  output logic [$clog2(LINE_BYTES):0]   ev_bytes_o,
  output logic [UTIL_FRAC:0]            ev_util_o,
  output logic [CW-1:0]                 acc_total_o,
  output logic [CW-1:0]                 load_total_o,
  output logic [CW-1:0]                 store_total_o,
  output logic [CW-1:0]                 byte_total_o,
  output logic [CW-1:0]                 span_total_o,
  output logic [CW-1:0]                 evict_total_o,
  output logic [CW-1:0]                 used_total_o,
  output logic [$clog2(LINE_BYTES):0]   min_used_o,
  output logic [$clog2(LINE_BYTES):0]   max_used_o
);
  localparam int SETS   = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LN_W   = AW - OFF_W;
  localparam int TAG_W  = LN_W - IDX_W;
  localparam int SZ_W   = $clog2(MAX_SIZE + 1);
  localparam int CNT_W  = OFF_W + 1;
  localparam int AGE_W  = $clog2(WAYS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int UTIL_W = UTIL_FRAC + 1;

  logic [TAG_W-1:0]      tag_q [SETS][WAYS];
  logic [LINE_BYTES-1:0] msk_q [SETS][WAYS];
  logic [AGE_W-1:0]      age_q [SETS][WAYS];
  logic [WAYS-1:0]       vld_q [SETS];

  phase_e          phase_q;
  logic [LN_W-1:0] sec_line_q;
  logic [SZ_W-1:0] sec_n_q;

  logic [LN_W-1:0]  sp_line, cur_line;
  logic [OFF_W-1:0] sp_off, cur_off;
  logic [SZ_W-1:0]  sp_first_n, sp_rest_n, cur_n;
  logic             sp_span, take, look;

  clu_addr_split #(
    .AW(AW), .OFF_W(OFF_W), .SZ_W(SZ_W), .LINE_BYTES(LINE_BYTES)
  ) u_split (
    .addr_i   (smp_addr_i),
    .size_i   (smp_size_i),
    .line_o   (sp_line),
    .off_o    (sp_off),
    .first_n_o(sp_first_n),
    .rest_n_o (sp_rest_n),
    .span_o   (sp_span)
  );

  assign smp_ready_o = (phase_q == PH_FIRST);
  assign take        = smp_ready_o && smp_valid_i;
  assign look        = take || (phase_q == PH_SECOND);
  assign cur_line    = (phase_q == PH_SECOND) ? sec_line_q : sp_line;
  assign cur_off     = (phase_q == PH_SECOND) ? '0 : sp_off;
  assign cur_n       = (phase_q == PH_SECOND) ? sec_n_q : sp_first_n;

  logic [IDX_W-1:0] cur_idx;
  logic [TAG_W-1:0] cur_tag;
  assign cur_idx = cur_line[IDX_W-1:0];
  assign cur_tag = cur_line[LN_W-1:IDX_W];

  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0][AGE_W-1:0] set_ages, new_ages;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_tags[w] = tag_q[cur_idx][w];
      set_ages[w] = age_q[cur_idx][w];
    end
  end

  logic             hit, victim_valid, evict;
  logic [WAY_W-1:0] sel_way;

  clu_way_select #(
    .WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W), .WAY_W(WAY_W)
  ) u_sel (
    .valid_i       (vld_q[cur_idx]),
    .tags_i        (set_tags),
    .ages_i        (set_ages),
    .tag_i         (cur_tag),
    .hit_o         (hit),
    .victim_valid_o(victim_valid),
    .way_o         (sel_way),
    .ages_o        (new_ages)
  );

  logic [LINE_BYTES-1:0] acc_mask, vic_mask;
  logic [CNT_W-1:0]      vic_cnt;
  assign acc_mask = (~({LINE_BYTES{1'b1}} << cur_n)) << cur_off;
  assign vic_mask = msk_q[cur_idx][sel_way];
  assign vic_cnt  = CNT_W'($countones(vic_mask));
  assign evict    = look && victim_valid;

  always_ff @(posedge clk_i) begin
    if (look) begin
      if (hit) msk_q[cur_idx][sel_way] <= vic_mask | acc_mask;
      else begin
        msk_q[cur_idx][sel_way] <= acc_mask;
        tag_q[cur_idx][sel_way] <= cur_tag;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end
      phase_q    <= PH_FIRST;
      sec_line_q <= '0;
      sec_n_q    <= '0;
      ev_valid_o <= 1'b0;
      ev_mask_o  <= '0;
      ev_bytes_o <= '0;
    end else begin
      if (look) begin
        vld_q[cur_idx][sel_way] <= 1'b1;
        for (int w = 0; w < WAYS; w++) age_q[cur_idx][w] <= new_ages[w];
      end
      if (take && sp_span) begin
        phase_q    <= PH_SECOND;
        sec_line_q <= sp_line + 1'b1;
        sec_n_q    <= sp_rest_n;
      end else begin
        phase_q <= PH_FIRST;
      end
      ev_valid_o <= evict;
      if (evict) begin
        ev_mask_o  <= vic_mask;
        ev_bytes_o <= vic_cnt;
      end
    end
  end

  logic [CNT_W+UTIL_FRAC-1:0] util_wide;
  assign util_wide = {ev_bytes_o, {UTIL_FRAC{1'b0}}} >> OFF_W;
  assign ev_util_o = util_wide[UTIL_W-1:0];

  clu_stats #(
    .CW(CW), .SZ_W(SZ_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)
  ) u_stats (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (take),
    .store_i      (smp_store_i),
    .size_i       (smp_size_i),
    .span_i       (sp_span),
    .evict_i      (evict),
    .evict_bytes_i(vic_cnt),
    .acc_o        (acc_total_o),
    .load_o       (load_total_o),
    .store_o      (store_total_o),
    .bytes_o      (byte_total_o),
    .span_o       (span_total_o),
    .evict_o      (evict_total_o),
    .used_o       (used_total_o),
    .min_o        (min_used_o),
    .max_o        (max_used_o)
  );
endmodule

// File: rtl/clu_monitor_chk.sv
module clu_monitor_chk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int SZ_W       = 5,
  parameter int CW         = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        smp_valid_i,
  input logic                        smp_ready_o,
  input logic [AW-1:0]               smp_addr_i,
  input logic [SZ_W-1:0]             smp_size_i,
  input logic                        ev_valid_o,
  input logic [$clog2(LINE_BYTES):0] ev_bytes_o,
  input logic [CW-1:0]               acc_total_o,
  input logic [CW-1:0]               load_total_o,
  input logic [CW-1:0]               store_total_o,
  input logic [CW-1:0]               evict_total_o,
  input logic [$clog2(LINE_BYTES):0] min_used_o,
  input logic [$clog2(LINE_BYTES):0] max_used_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [OFF_W+SZ_W:0] end_pos;
  assign end_pos = (OFF_W + SZ_W + 1)'(smp_addr_i[OFF_W-1:0]) + (OFF_W + SZ_W + 1)'(smp_size_i);

  AST_SPAN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && smp_ready_o && end_pos > LINE_BYTES |=> !smp_ready_o); // R6
  AST_STALL_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_ready_o |=> smp_ready_o); // R6
  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && smp_ready_o |=> acc_total_o == $past(acc_total_o) + 1'b1); // R7
  AST_LDST_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_total_o + store_total_o == acc_total_o); // R7
  AST_EVICT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |-> evict_total_o == $past(evict_total_o) + 1'b1); // R8
  AST_REPORT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |-> ev_bytes_o != 0 && ev_bytes_o <= LINE_BYTES); // R4
  AST_MIN_MAX_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_total_o != 0 |-> min_used_o <= max_used_o); // R9
  AST_MIN_MAX_COVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_o |-> max_used_o >= ev_bytes_o && min_used_o <= ev_bytes_o); // R9
endmodule

bind clu_monitor clu_monitor_chk #(
  .AW(AW), .LINE_BYTES(LINE_BYTES), .SZ_W(SZ_W), .CW(CW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smp_valid_i  (smp_valid_i),
  .smp_ready_o  (smp_ready_o),
  .smp_addr_i   (smp_addr_i),
  .smp_size_i   (smp_size_i),
  .ev_valid_o   (ev_valid_o),
  .ev_bytes_o   (ev_bytes_o),
  .acc_total_o  (acc_total_o),
  .load_total_o (load_total_o),
  .store_total_o(store_total_o),
  .evict_total_o(evict_total_o),
  .min_used_o   (min_used_o),
  .max_used_o   (max_used_o)
);

// File: tb/tb_clu_monitor.sv
module tb_clu_monitor;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic        smp_ready_o;
  logic [31:0] smp_addr_i = '0;
  logic [4:0]  smp_size_i = '0;
  logic        smp_store_i = 1'b0;
  logic        ev_valid_o;
  logic [63:0] ev_mask_o;
  logic [6:0]  ev_bytes_o;
  logic [8:0]  ev_util_o;
  logic [31:0] acc_total_o, load_total_o, store_total_o, byte_total_o;
  logic [31:0] span_total_o, evict_total_o, used_total_o;
  logic [6:0]  min_used_o, max_used_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clu_monitor dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .smp_valid_i(smp_valid_i), .smp_ready_o(smp_ready_o),
    .smp_addr_i(smp_addr_i), .smp_size_i(smp_size_i), .smp_store_i(smp_store_i),
    .ev_valid_o(ev_valid_o), .ev_mask_o(ev_mask_o), .ev_bytes_o(ev_bytes_o),
    .ev_util_o(ev_util_o),
    .acc_total_o(acc_total_o), .load_total_o(load_total_o),
    .store_total_o(store_total_o), .byte_total_o(byte_total_o),
    .span_total_o(span_total_o), .evict_total_o(evict_total_o),
    .used_total_o(used_total_o), .min_used_o(min_used_o), .max_used_o(max_used_o)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [4:0]  size;
    logic        st;
    logic        ev;
    logic [6:0]  cnt;
    logic [63:0] msk;
  } vec_t;

  // set 1, tags 0..7; R5: the hit in entry 5 spares tag 0, tag 1 goes first
  localparam vec_t VECS [10] = '{
    '{32'h0000_0040, 5'd8,  1'b0, 1'b0, 7'd0,  64'h0},
    '{32'h0000_0048, 5'd4,  1'b1, 1'b0, 7'd0,  64'h0},
    '{32'h0000_1040, 5'd16, 1'b0, 1'b0, 7'd0,  64'h0},
    '{32'h0000_2040, 5'd1,  1'b0, 1'b0, 7'd0,  64'h0},
    '{32'h0000_3040, 5'd2,  1'b0, 1'b0, 7'd0,  64'h0},
    '{32'h0000_0060, 5'd4,  1'b1, 1'b0, 7'd0,  64'h0},
    '{32'h0000_4040, 5'd4,  1'b0, 1'b1, 7'd16, 64'h0000_0000_0000_FFFF},
    '{32'h0000_5040, 5'd8,  1'b1, 1'b1, 7'd1,  64'h0000_0000_0000_0001},
    '{32'h0000_6040, 5'd4,  1'b0, 1'b1, 7'd2,  64'h0000_0000_0000_0003},
    '{32'h0000_7040, 5'd1,  1'b0, 1'b1, 7'd16, 64'h0000_000F_0000_0FFF}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // entered and left at a negedge; report of the first lookup is visible on return
  task automatic send(input logic [31:0] a, input logic [4:0] sz, input logic st);
    while (!smp_ready_o) @(negedge clk);
    smp_addr_i  = a;
    smp_size_i  = sz;
    smp_store_i = st;
    smp_valid_i = 1'b1;
    @(negedge clk);
    smp_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 ready", smp_ready_o, 1);
    chk("R10 ev_valid", ev_valid_o, 0);
    chk("R10 acc", acc_total_o, 0);
    chk("R10 evict", evict_total_o, 0);
    chk("R9 min reset", min_used_o, 64);
    chk("R9 max reset", max_used_o, 0);

    for (int i = 0; i < 10; i++) begin
      send(VECS[i].addr, VECS[i].size, VECS[i].st);
      chk(VECS[i].ev ? "R4/R5 report" : "R2/R3 no report", ev_valid_o, VECS[i].ev);
      if (VECS[i].ev) begin
        chk("R4 bytes", ev_bytes_o, VECS[i].cnt);
        chk("R4 mask", ev_mask_o, VECS[i].msk);
        chk("R4 util", ev_util_o, {VECS[i].cnt, 2'b00});
      end
    end
    chk("R7 acc", acc_total_o, 10);
    chk("R7 loads", load_total_o, 7);
    chk("R7 stores", store_total_o, 3);
    chk("R7 bytes", byte_total_o, 52);
    chk("R8 evict", evict_total_o, 4);
    chk("R8 used", used_total_o, 35);
    chk("R9 min", min_used_o, 1);
    chk("R9 max", max_used_o, 16);

    // R6 boundary: ends exactly at line end, no span; R1 other set untouched
    send(32'h0000_003C, 5'd4, 1'b0);
    chk("R6 no stall at boundary", smp_ready_o, 1);
    chk("R1 other set no report", ev_valid_o, 0);
    send(32'h0000_0030, 5'd16, 1'b0);
    chk("R6 no span count", span_total_o, 0);

    // fill sets 10 and 11 with tags 1..4
    for (int t = 1; t <= 4; t++) begin
      send((t << 12) | 32'h280, 5'd1, 1'b0);
      send((t << 12) | 32'h2C0, 5'd1, 1'b0);
    end
    chk("R3 fills no evict", evict_total_o, 4);

    // span from set 10 (bytes 62,63) into set 11 (bytes 0,1), both evict
    send(32'h0000_92BE, 5'd4, 1'b0);
    chk("R6 stall", smp_ready_o, 0);
    chk("R6 first half report", ev_valid_o, 1);
    chk("R6 first half bytes", ev_bytes_o, 1);
    @(negedge clk);
    chk("R6 ready back", smp_ready_o, 1);
    chk("R6 second half report", ev_valid_o, 1);
    chk("R6 second half mask", ev_mask_o, 64'h1);
    chk("R6 span count", span_total_o, 1);
    chk("R8 two evictions", evict_total_o, 6);
    chk("R7 span counted once", acc_total_o, 21);

    for (int t = 5; t <= 8; t++) begin
      send((t << 12) | 32'h280, 5'd1, 1'b0);
      chk("R5 set10 evict", ev_valid_o, 1);
      chk("R4 set10 bytes", ev_bytes_o, (t == 8) ? 2 : 1);
      if (t == 8) chk("R6 first half mask", ev_mask_o, 64'hC000_0000_0000_0000);
    end
    for (int t = 5; t <= 8; t++) begin
      send((t << 12) | 32'h2C0, 5'd1, 1'b0);
      chk("R5 set11 evict", ev_valid_o, 1);
      if (t == 8) chk("R6 second half mask", ev_mask_o, 64'h3);
    end

    chk("R7 acc final", acc_total_o, 29);
    chk("R7 loads final", load_total_o, 26);
    chk("R7 bytes final", byte_total_o, 92);
    chk("R8 evict final", evict_total_o, 14);
    chk("R8 used final", used_total_o, 47);
    chk("R9 min final", min_used_o, 1);
    chk("R9 max final", max_used_o, 16);

    finish_run();
  end
endmodule